// File: doc/BRIEF.md
# Single-Cycle Memory Bus Master with Wait States

This block sits between a processor core and a simple asynchronous-style memory. It has three separate buses toward memory: an address bus, a data bus with separate write and read lanes, and a control bus with active-high read and write strobes and a ready return. The core side is a plain command port: a valid flag, a write flag, an address and write data. A command is taken only while the block reports `idle`. The block then runs exactly one read or write cycle and signals its end with a one-clock `done` pulse, or an `err` pulse if memory never answers.

A cycle with no wait states takes three clocks. In the first clock the address (and, for a write, the data) is driven and the strobe rises. Memory ready is sampled at the end of the second clock. The final clock captures read data and releases the strobe. While ready is low, wait clocks are inserted between the second clock and the final one. After a parameterised number of wait clocks with no ready, the block ends the cycle with an error instead.

Top module: `mem_cycle_master`

## Requirements
- R1: After reset `idle` is 1 and `mem_rd`, `mem_wr`, `done` and `err` are all 0.
- R2: A read command sampled with `req_valid`=1 while `idle`=1 raises `mem_rd` in the next clock with `mem_addr` equal to the command address. With `mem_ready` high at its first sample, `mem_rd` stays high for exactly 3 clocks.
- R3: A write command raises `mem_wr` in the next clock with `mem_addr` and `mem_wdata` both driven. With no waits, `mem_wr` stays high for exactly 3 clocks and `mem_rd` stays 0.
- R4: `done` is high for exactly one clock, which is the last clock of the strobe. For a read, `rd_data` equals `mem_rdata` in that clock and holds that value until the next read completes. A write or a failed cycle leaves `rd_data` unchanged.
- R5: `mem_ready` is sampled at the end of the second strobe clock and at the end of each wait clock. Each sample taken low adds exactly one clock, so a cycle with N low samples lasts 3+N clocks.
- R6: `mem_addr` and `mem_wdata` do not change from the first through the final clock of a cycle.
- R7: A request presented while a cycle is in progress (`idle`=0) is ignored. It does not alter the bus, and no further cycle follows it.
- R8: With `TIMEOUT_WAITS`=16, a cycle that sees 16 low ready samples followed by a high one completes normally in 19 clocks. A 17th low sample instead makes the 19th clock a final clock with `err`=1 and `done`=0, and the strobe then drops.
- R9: `mem_rd` and `mem_wr` are never high in the same clock. After the final clock both are low and `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Command write data |
| idle | output | 1 | Block can take a command this clock |
| done | output | 1 | One-clock pulse in the final clock of a successful cycle |
| err | output | 1 | One-clock pulse in the final clock of a timed-out cycle |
| rd_data | output | DATA_W | Read result, valid with `done` and held afterwards |
| mem_addr | output | ADDR_W | Address bus |
| mem_wdata | output | DATA_W | Write data bus |
| mem_rdata | input | DATA_W | Read data bus |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_ready | input | 1 | Memory ready, sampled to end the wait phase |

## Verification
On every clock the assertions enforce several rules: the two strobes are never high together, `done` and `err` never coincide and last one clock, and the strobe drops after a final clock. They also check that a command taken while idle starts a strobe at once, that the address holds while a strobe is up, and that no cycle exceeds its timeout length. A strobe-clock counter in the checker ties `err` to the exact timeout length. Only the bench scenarios show exact cycle lengths for chosen numbers of low ready samples, the boundary between 16 and 17 waits, and correct read data and its retention across writes and failures. They also show that a mid-cycle request leaves no trace.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SAMP  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_LAST  = 3'd4,
    PH_FAIL  = 3'd5
  } phase_t;

  // Next phase after a ready sample point (second clock or a wait clock).
  function automatic phase_t after_sample(input logic rdy, input logic at_limit);
    if (rdy)
      return PH_LAST;
    else if (at_limit)
      return PH_FAIL;
    else
      return PH_WAIT;
  endfunction

  // Phases during which a strobe is active.
  function automatic logic strobe_phase(input phase_t ph);
    return (ph == PH_ADDR) || (ph == PH_SAMP) || (ph == PH_WAIT) ||
           (ph == PH_LAST) || (ph == PH_FAIL);
  endfunction

  // Length in clocks of a cycle that sees `lows` low ready samples.
  function automatic int unsigned cycle_clocks(input int unsigned lows,
                                               input int unsigned limit);
    return (lows > limit) ? 3 + limit : 3 + lows;
  endfunction

endpackage

// File: rtl/mcm_wait_ctr.sv
module mcm_wait_ctr #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clear)
      count <= '0;
    else if (bump)
      count <= count + CW'(1);
  end

  assign at_limit = (count == CW'(LIMIT));
endmodule

// File: rtl/mcm_phase_seq.sv
module mcm_phase_seq
  import mcm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   rdy,
  input  logic   at_limit,
  output phase_t phase,
  output logic   enter_wait
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start) nxt = PH_ADDR;
      PH_ADDR: nxt = PH_SAMP;
      PH_SAMP,
      PH_WAIT: nxt = after_sample(rdy, at_limit);
      PH_LAST,
      PH_FAIL: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign enter_wait = (nxt == PH_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= PH_IDLE;
    else
      phase <= nxt;
  end
endmodule

// File: rtl/mcm_bus_regs.sv
module mcm_bus_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (load) begin
      is_write <= cmd_write;
      addr_q   <= cmd_addr;
      wdata_q  <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (capture)
      rdata_q <= bus_rdata;
  end
endmodule

// File: rtl/mem_cycle_master.sv
module mem_cycle_master
  import mcm_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned TIMEOUT_WAITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              idle,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              mem_ready
);
  localparam int unsigned CW = $clog2(TIMEOUT_WAITS + 1);

  phase_t        phase;
  logic          enter_wait;
  logic [CW-1:0] wait_count;
  logic          at_limit;
  logic          is_write;
  logic [DATA_W-1:0] rdata_q;

  // Named internal events, used by the checker.
  logic ev_accept;
  logic ev_final;
  logic ev_timeout;
  logic ev_strobe;

  assign idle       = (phase == PH_IDLE);
  assign ev_accept  = idle && req_valid;
  assign ev_final   = (phase == PH_LAST) || (phase == PH_FAIL);
  assign ev_timeout = (phase == PH_FAIL);
  assign ev_strobe  = strobe_phase(phase);

  mcm_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_accept),
    .rdy        (mem_ready),
    .at_limit   (at_limit),
    .phase      (phase),
    .enter_wait (enter_wait)
  );

  mcm_wait_ctr #(.LIMIT(TIMEOUT_WAITS)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_accept),
    .bump     (enter_wait),
    .count    (wait_count),
    .at_limit (at_limit)
  );

  mcm_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .cmd_write (req_write),
    .cmd_addr  (req_addr),
    .cmd_wdata (req_wdata),
    .capture   ((phase == PH_LAST) && !is_write),
    .bus_rdata (mem_rdata),
    .is_write  (is_write),
    .addr_q    (mem_addr),
    .wdata_q   (mem_wdata),
    .rdata_q   (rdata_q)
  );

  assign mem_rd  = ev_strobe && !is_write;
  assign mem_wr  = ev_strobe &&  is_write;
  assign done    = (phase == PH_LAST);
  assign err     = ev_timeout;
  assign rd_data = (done && !is_write) ? mem_rdata : rdata_q;

endmodule

// File: rtl/mcm_checker.sv
module mcm_checker #(
  parameter int unsigned TIMEOUT_WAITS = 16,
  parameter int unsigned ADDR_W        = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              done,
  input logic              err,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_accept,
  input logic              ev_final,
  input logic              ev_strobe
);
  localparam int unsigned MAXLEN = 3 + TIMEOUT_WAITS;

  int unsigned strobe_clks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      strobe_clks <= 0;
    else if (ev_strobe && !ev_final)
      strobe_clks <= strobe_clks + 1;
    else
      strobe_clks <= 0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !(mem_rd || mem_wr || done || err));

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (mem_rd || mem_wr) && !idle);

  p_min_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !done && !err ##1 !done && !err);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_timeout_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (strobe_clks == MAXLEN - 1));

  p_never_overlong_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_clks < MAXLEN);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> $stable(mem_addr));

  p_no_dual_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(mem_rd || mem_wr) && idle);

  p_busy_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !ev_final) |=> !idle);
endmodule

bind mem_cycle_master mcm_checker #(
  .TIMEOUT_WAITS(TIMEOUT_WAITS),
  .ADDR_W       (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle      (idle),
  .done      (done),
  .err       (err),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .ev_accept (ev_accept),
  .ev_final  (ev_final),
  .ev_strobe (ev_strobe)
);

// File: tb/sim_mem_cycle_master.sv
`timescale 1ns/1ps
module sim_mem_cycle_master;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic idle, done, err, mem_rd, mem_wr;
  logic [DW-1:0] rd_data, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] last_rd = '0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  mem_cycle_master #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_WAITS(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done),
    .err(err), .rd_data(rd_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_ready(mem_ready)
  );

  // {write, addr, wdata, rdata, lows}
  localparam int VN = 8;
  localparam logic [53:0] VEC [VN] = '{
    {1'b0, 16'h1234, 16'h0000, 16'hBEEF, 5'd0},
    {1'b1, 16'h2000, 16'hA5A5, 16'h0000, 5'd0},
    {1'b0, 16'h00FF, 16'h0000, 16'h1357, 5'd1},
    {1'b1, 16'hFFFE, 16'h5A5A, 16'h0000, 5'd3},
    {1'b0, 16'h8001, 16'h0000, 16'hC0DE, 5'd5},
    {1'b1, 16'h0004, 16'hFFFF, 16'h0000, 5'd2},
    {1'b0, 16'h7777, 16'h0000, 16'h0001, 5'd9},
    {1'b0, 16'h0000, 16'h0000, 16'hFFFF, 5'd0}
  };

  function automatic int exp_len(input int lows);
    return (lows > LIM) ? LIM + 3 : lows + 3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic [DW-1:0] rdv,
                     input int lows, input bit poke);
    int k;
    bit fin;
    bit got_done;
    bit got_err;
    bit bus_ok;
    logic [DW-1:0] fin_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    mem_rdata = rdv; mem_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; fin = 0; bus_ok = 1; got_done = 0; got_err = 0; fin_rd = '0;
    while (!fin && k < 40) begin
      if (wr ? !(mem_wr && !mem_rd) : !(mem_rd && !mem_wr)) bus_ok = 0;
      if (mem_addr != a) bus_ok = 0;
      if (wr && mem_wdata != wd) bus_ok = 0;
      mem_ready = (k >= 1 + lows);
      if (poke && k == 1) begin
        req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      if (done || err) begin
        fin = 1; got_done = done; got_err = err; fin_rd = rd_data;
      end else begin
        k++;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    check(bus_ok, wr ? "R3/R6" : "R2/R6", "strobe/addr/data over cycle", bus_ok, 1);
    check(k + 1 == exp_len(lows), "R5", "cycle length", k + 1, exp_len(lows));
    if (lows > LIM) begin
      check(got_err && !got_done, "R8", "timeout err", {got_err, got_done}, 2'b10);
      check(fin_rd == last_rd, "R4", "rd_data kept on err", fin_rd, last_rd);
    end else begin
      check(got_done && !got_err, "R4", "done in final clock", {got_done, got_err}, 2'b10);
      if (!wr) begin
        check(fin_rd == rdv, "R4", "rd_data with done", fin_rd, rdv);
        last_rd = rdv;
      end else begin
        check(fin_rd == last_rd, "R4", "rd_data kept on write", fin_rd, last_rd);
      end
    end
    mem_ready = 1'b0;
    @(negedge clk);
    check(!mem_rd && !mem_wr && idle && !done && !err, "R9", "released after final",
          {mem_rd, mem_wr, idle, done, err}, 5'b00100);
    check(rd_data == last_rd, "R4", "rd_data held", rd_data, last_rd);
    if (poke) begin
      @(negedge clk);
      check(idle && !mem_rd && !mem_wr, "R7", "no cycle from busy request",
            {idle, mem_rd, mem_wr}, 3'b100);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(idle && !mem_rd && !mem_wr && !done && !err, "R1", "reset state",
          {idle, mem_rd, mem_wr, done, err}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(idle && !mem_rd && !mem_wr && !done && !err, "R1", "after reset release",
          {idle, mem_rd, mem_wr, done, err}, 5'b10000);

    for (int i = 0; i < VN; i++) begin
      run(VEC[i][53], VEC[i][52:37], VEC[i][36:21], VEC[i][20:5],
          int'(VEC[i][4:0]), 1'b0);
    end

    // R2: first strobe clock follows acceptance directly
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4242;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_rd && !idle && mem_addr == 16'h4242, "R2", "strobe in first clock",
          {mem_rd, idle}, 2'b10);
    mem_ready = 1'b1; mem_rdata = 16'h9999;
    @(negedge clk); @(negedge clk);
    check(done && rd_data == 16'h9999, "R2", "third clock final", rd_data, 16'h9999);
    last_rd = 16'h9999;
    mem_ready = 1'b0;
    @(negedge clk);

    // R7: request during a busy cycle
    run(1'b1, 16'h3030, 16'h0F0F, 16'h0000, 2, 1'b1);
    run(1'b0, 16'h3131, 16'h0000, 16'h6060, 4, 1'b1);

    // R8: timeout boundary
    run(1'b0, 16'h5000, 16'h0000, 16'hABCD, LIM, 1'b0);
    run(1'b0, 16'h5002, 16'h0000, 16'h1111, LIM + 1, 1'b0);
    run(1'b1, 16'h5004, 16'h2222, 16'h0000, LIM + 5, 1'b0);

    // R1: reset mid-cycle returns to the quiet state
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h6000;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(idle && !mem_rd && !mem_wr && !done && !err, "R1", "reset mid-cycle",
          {idle, mem_rd, mem_wr, done, err}, 5'b10000);
    rst_n = 1'b1;
    last_rd = '0;
    run(1'b0, 16'h6001, 16'h0000, 16'h7E7E, 0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule